// File: doc/BRIEF.md
# MDIO PHY Status Polling Engine

This block is a management-bus master. It keeps per-port link and duplex state for a row of PHYs without any help from software. It reads from every PHY in turn, over and over, using clause-22 read frames on MDC/MDIO. From each PHY it takes the basic status register (1), the auto-negotiation advertisement register (4) and the link-partner ability register (5), always in that order. Once a PHY has been read it moves on to the next address. After the last address it goes back to address 0.

The results feed three per-port outputs. `link_up` follows the link bit that was last read. `port_rst_n` holds a port's logic in reset while that port's link has failed. `full_duplex` comes from auto-negotiation, unless the port has auto-negotiation disabled by strap, in which case it comes from that port's duplex strap. Three strap inputs are captured while `rst_n` is low and are frozen after that: one disables auto-negotiation, one sets the duplex, and one active-low strap forces the link up on every port. The block only reads. It does not write to PHYs and does not detect speed.

Top module: `mdio_poll_engine`

## Requirements
- R1: The PHY address steps 0, 1, ... NUM_PORTS-1 and then wraps back to 0. Each PHY gets three read frames in a fixed order: register 1, then register 4, then register 5.
- R2: A read frame is made of 32 ones, then 01, then 10, then the 5-bit PHY address MSB first, then the 5-bit register address MSB first. `mdio_oe` is high for exactly these 46 bits. It goes low for a 2-bit turnaround and stays low for the 16 data bits. The data bits are sampled MSB first on rising MDC edges. `mdio_o` and `mdio_oe` only change while MDC is low.
- R3: MDC is a square wave with a period of 2*MDC_HALF system clocks. MDC_HALF must be at least 2.
- R4: When a register 1 read returns bit 2 = 1, `link_up` for that port is set. When it returns bit 2 = 0, `link_up` for that port is cleared. `port_rst_n` is low exactly while `link_up` is low. No other event changes `link_up`.
- R5: If `force_link_n` is low during reset, every port shows `link_up` = 1 and `port_rst_n` = 1 until the next reset, whatever the PHYs report.
- R6: The straps are sampled only while `rst_n` is low. Changing them after reset has no effect on the outputs.
- R7: This applies to a port whose `aneg_off_strap` bit was 0. After its register 5 read, if the register 1 read of the same visit had bit 5 = 1, `full_duplex` is updated from the AND of registers 4 and 5. The AND is checked in priority order: bit 8 (100 full), bit 7 (100 half), bit 6 (10 full), bit 5 (10 half). The result is 1 only if the first set bit found is bit 8 or bit 6. It is 0 if none of these bits is set.
- R8: For a port with auto-negotiation enabled, `full_duplex` keeps its previous value when the register 1 read of that visit had bit 5 = 0.
- R9: For a port whose `aneg_off_strap` bit was 1, `full_duplex` always equals that port's `duplex_strap` bit (1 = full), whatever the PHY registers hold.
- R10: After reset, without forcing, `link_up` and `port_rst_n` are 0. `full_duplex` is 0 for ports with auto-negotiation enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are captured while it is low |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven by the master |
| mdio_oe | output | 1 | Output enable for mdio_o (1 = master drives the line) |
| mdio_i | input | 1 | Management data read back from the line |
| aneg_off_strap | input | NUM_PORTS | Per-port strap: 1 disables auto-negotiation |
| duplex_strap | input | NUM_PORTS | Per-port duplex strap: 1 = full duplex |
| force_link_n | input | 1 | Global strap: 0 forces every link up |
| link_up | output | NUM_PORTS | Per-port link state |
| full_duplex | output | NUM_PORTS | Per-port resolved duplex: 1 = full |
| port_rst_n | output | NUM_PORTS | Per-port reset, low while the link has failed |

## Verification
Some properties are checked by assertions on every cycle:
- the MDIO outputs hold steady while MDC is high;
- MDC toggles only at the divider's terminal count;
- the address wraps from the last port back to port 0;
- a port's link and duplex bits change only right after a read of the matching register for that port;
- a forced link stays up, and a strapped port's duplex always matches its strap.

Other behaviour only the bench scenarios can show:
- the exact bit pattern of each frame;
- the priority used to resolve duplex;
- that a status read with auto-negotiation incomplete leaves duplex unchanged;
- that strap changes after reset are ignored.

// File: rtl/mdio_poll_pkg.sv
// Package: mdio_poll_pkg
// Shared frame constants, poll-step type and duplex resolution for the
// MDIO polling engine. Assumes clause-22 read frames of 64 MDC bits.
package mdio_poll_pkg;

    localparam int FRAME_BITS = 64;   // preamble through last data bit
    localparam int DRIVE_BITS = 46;   // bits during which the master drives
    localparam int DATA_FIRST = 48;   // index of the first data bit

    typedef enum logic [1:0] {
        RD_BMSR = 2'd0,   // basic status register
        RD_ADV  = 2'd1,   // own advertisement register
        RD_LPA  = 2'd2    // link partner ability register
    } poll_step_t;

    // Register address read at each step of a PHY visit.
    function automatic logic [4:0] step_reg(poll_step_t s);
        case (s)
            RD_BMSR: return 5'd1;
            RD_ADV:  return 5'd4;
            default: return 5'd5;
        endcase
    endfunction

    // Highest common ability: 100 full > 100 half > 10 full > 10 half.
    function automatic logic resolve_full(logic [15:0] adv, logic [15:0] lpa);
        logic [15:0] common;
        common = adv & lpa;
        if (common[8])      return 1'b1;
        else if (common[7]) return 1'b0;
        else if (common[6]) return 1'b1;
        else                return 1'b0;
    endfunction

endpackage

// File: rtl/mdio_clk_gen.sv
// Module: mdio_clk_gen
// Divides the system clock into MDC. MDC toggles every MDC_HALF clocks.
// Also gives one-cycle strobes in the cycle just before MDC rises or falls.
// Assumes MDC_HALF >= 2 so that the frame logic can restart between frames.
module mdio_clk_gen #(
    parameter int MDC_HALF = 20
) (
    input  logic clk,
    input  logic rst_n,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CW = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;
    localparam logic [CW-1:0] TERM = CW'(MDC_HALF - 1);

    logic [CW-1:0] cnt;

    // Half-period counter; MDC flips at terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (cnt == TERM) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign rise_stb = (cnt == TERM) && !mdc;
    assign fall_stb = (cnt == TERM) &&  mdc;

    // R3: MDC edges only come from the terminal count
    assert_mdc_rate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mdc) || $fell(mdc)) |-> ($past(cnt) == TERM));

endmodule

// File: rtl/mdio_frame_io.sv
// Module: mdio_frame_io
// Shifts out one clause-22 read frame and captures its 16 data bits.
// Bits change at MDC fall strobes. Data is sampled at MDC rise strobes.
// A frame starts at the first fall strobe with start high while idle.
// done pulses once rd_data holds the whole word.
module mdio_frame_io
    import mdio_poll_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rise_stb,
    input  logic        fall_stb,
    input  logic        start,
    input  logic [4:0]  phy_addr,
    input  logic [4:0]  reg_addr,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data
);
    localparam logic [5:0] LAST_BIT = 6'(FRAME_BITS - 1);

    logic [FRAME_BITS-1:0] tx_word;
    logic [5:0]            idx;

    // Frame sequencing: load, advance bit index, capture data, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            idx     <= '0;
            tx_word <= '0;
            rd_data <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start && fall_stb) begin
                    busy    <= 1'b1;
                    idx     <= '0;
                    tx_word <= {32'hFFFF_FFFF, 2'b01, 2'b10, phy_addr, reg_addr,
                                2'b00, 16'h0000};
                end
            end else begin
                if (fall_stb && idx != LAST_BIT)
                    idx <= idx + 1'b1;
                if (rise_stb && idx >= 6'(DATA_FIRST)) begin
                    rd_data <= {rd_data[14:0], mdio_i};
                    if (idx == LAST_BIT) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end
            end
        end
    end

    // Drive the current frame bit; release the line for turnaround and data.
    assign mdio_o  = busy ? tx_word[LAST_BIT - idx] : 1'b1;
    assign mdio_oe = busy && (idx < 6'(DRIVE_BITS));

    // R2: the master lets go of the line exactly at the turnaround
    assert_oe_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdio_oe) |-> (busy && idx == 6'(DRIVE_BITS)));

endmodule

// File: rtl/mdio_poll_seq.sv
// Module: mdio_poll_seq
// Walks PHY addresses 0..NUM_PORTS-1 and, for each one, the register steps
// status -> advertisement -> partner ability. It moves on each time a frame
// is done and asks for a new frame whenever the frame engine is idle.
module mdio_poll_seq
    import mdio_poll_pkg::*;
#(
    parameter int NUM_PORTS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         busy,
    input  logic                         done,
    output logic                         start,
    output logic [$clog2(NUM_PORTS)-1:0] port,
    output poll_step_t                   step
);
    localparam int PW = $clog2(NUM_PORTS);
    localparam logic [PW-1:0] LAST_PORT = PW'(NUM_PORTS - 1);

    // Advance step, and port after the last step, on every finished frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port <= '0;
            step <= RD_BMSR;
        end else if (done) begin
            case (step)
                RD_BMSR: step <= RD_ADV;
                RD_ADV:  step <= RD_LPA;
                default: begin
                    step <= RD_BMSR;
                    port <= (port == LAST_PORT) ? '0 : port + 1'b1;
                end
            endcase
        end
    end

    assign start = !busy;

    // R1: after the last register of the last PHY, go back to PHY 0, status read
    assert_addr_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && step == RD_LPA && port == LAST_PORT) |=> (port == '0 && step == RD_BMSR));

endmodule

// File: rtl/mdio_poll_engine.sv
// Module: mdio_poll_engine (top)
// Polls NUM_PORTS PHYs over MDC/MDIO in the background and keeps each
// port's link, duplex and reset outputs. Straps are captured while rst_n
// is low. Assumes PHY address = port number and MDC_HALF >= 2.
module mdio_poll_engine
    import mdio_poll_pkg::*;
#(
    parameter int NUM_PORTS = 8,
    parameter int MDC_HALF  = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic                 mdc,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    input  logic                 mdio_i,
    input  logic [NUM_PORTS-1:0] aneg_off_strap,
    input  logic [NUM_PORTS-1:0] duplex_strap,
    input  logic                 force_link_n,
    output logic [NUM_PORTS-1:0] link_up,
    output logic [NUM_PORTS-1:0] full_duplex,
    output logic [NUM_PORTS-1:0] port_rst_n
);
    localparam int PW = $clog2(NUM_PORTS);

    logic          rise_stb, fall_stb;
    logic          start, busy, done;
    logic [15:0]   rd_data;
    logic [PW-1:0] port;
    poll_step_t    step;

    logic [NUM_PORTS-1:0] aneg_off_q, duplex_q, link_q, fdx_q;
    logic                 force_q;
    logic [15:0]          bmsr_tmp, adv_tmp;

    mdio_clk_gen #(.MDC_HALF(MDC_HALF)) u_clk (
        .clk(clk), .rst_n(rst_n), .mdc(mdc),
        .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    mdio_frame_io u_frame (
        .clk(clk), .rst_n(rst_n), .rise_stb(rise_stb), .fall_stb(fall_stb),
        .start(start), .phy_addr(5'(port)), .reg_addr(step_reg(step)),
        .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .busy(busy), .done(done), .rd_data(rd_data)
    );

    mdio_poll_seq #(.NUM_PORTS(NUM_PORTS)) u_seq (
        .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
        .start(start), .port(port), .step(step)
    );

    // Capture the straps while in reset and hold them afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aneg_off_q <= aneg_off_strap;
            duplex_q   <= duplex_strap;
            force_q    <= !force_link_n;
        end
    end

    // Update per-port link and duplex from each finished read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_q   <= force_link_n ? '0 : '1;
            fdx_q    <= aneg_off_strap & duplex_strap;
            bmsr_tmp <= '0;
            adv_tmp  <= '0;
        end else if (done) begin
            case (step)
                RD_BMSR: begin
                    bmsr_tmp <= rd_data;
                    if (!force_q)
                        link_q[port] <= rd_data[2];
                end
                RD_ADV: adv_tmp <= rd_data;
                default: begin
                    if (aneg_off_q[port])
                        fdx_q[port] <= duplex_q[port];
                    else if (bmsr_tmp[5])
                        fdx_q[port] <= resolve_full(adv_tmp, rd_data);
                end
            endcase
        end
    end

    assign link_up     = link_q;
    assign port_rst_n  = link_q;
    assign full_duplex = fdx_q;

    // R2: the line is changed only while MDC is low
    assert_mdio_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port_chk
        // R5: a forced link never drops
        assert_force_link_R5: assert property (@(posedge clk) disable iff (!rst_n)
            force_q |-> link_up[i]);
        // R9: a strapped port's duplex follows its strap
        assert_strap_duplex_R9: assert property (@(posedge clk) disable iff (!rst_n)
            aneg_off_q[i] |-> (full_duplex[i] == duplex_q[i]));
        // R4: link changes only right after this port's status read
        assert_link_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (link_up[i] != $past(link_up[i])) |->
            $past(done && step == RD_BMSR && port == PW'(i)));
        // R8: duplex changes only right after this port's partner read
        assert_duplex_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (full_duplex[i] != $past(full_duplex[i])) |->
            $past(done && step == RD_LPA && port == PW'(i)));
    end

endmodule

// File: tb/mdio_poll_engine_bench.sv
// Directed bench. A behavioural PHY model decodes each read frame and
// answers from per-PHY register arrays. Each task checks its own scenario.
module mdio_poll_engine_bench;
    localparam int N    = 8;
    localparam int HALF = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mdc, mdio_o, mdio_oe;
    logic mdio_i = 1'b1;
    logic [N-1:0] aneg_off_strap, duplex_strap;
    logic force_link_n;
    logic [N-1:0] link_up, full_duplex, port_rst_n;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    mdio_poll_engine #(.NUM_PORTS(N), .MDC_HALF(HALF)) u_mdio_poll_engine (
        .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i), .aneg_off_strap(aneg_off_strap), .duplex_strap(duplex_strap),
        .force_link_n(force_link_n), .link_up(link_up), .full_duplex(full_duplex),
        .port_rst_n(port_rst_n)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc++;

    // PHY register model
    logic [15:0] r1 [N];
    logic [15:0] r4 [N];
    logic [15:0] r5 [N];

    // Frame decoder state
    logic [45:0] hist = '0;
    int nbits = 0, frames = 0, sweeps = 0, fmt_err = 0, seq_err = 0;
    int exp_phy = 0, exp_step = 0;
    logic [15:0] rd_word = '0;
    int rd_pos = 0;
    bit rd_act = 0;

    function automatic logic [4:0] reg_of(int s);
        return (s == 0) ? 5'd1 : (s == 1) ? 5'd4 : 5'd5;
    endfunction

    // Decode the master's header bits; check format and order (R1, R2).
    always @(posedge mdc) begin
        if (mdio_oe) begin
            hist = {hist[44:0], mdio_o};
            nbits++;
        end else if (nbits > 0) begin
            logic [4:0] phy, rg;
            phy = hist[9:5];
            rg  = hist[4:0];
            if (nbits != 46 || hist[45:14] != 32'hFFFF_FFFF || hist[13:10] != 4'b0110)
                fmt_err++;
            if (int'(phy) != exp_phy || rg != reg_of(exp_step))
                seq_err++;
            if (exp_step == 2) begin
                exp_step = 0;
                exp_phy  = (exp_phy + 1) % N;
            end else exp_step++;
            if (phy == 5'd0 && rg == 5'd1) sweeps++;
            rd_word = (phy >= N) ? 16'hFFFF :
                      (rg == 5'd1) ? r1[phy] : (rg == 5'd4) ? r4[phy] : r5[phy];
            rd_pos = -1;
            rd_act = 1;
            frames++;
            nbits = 0;
        end
    end

    // Answer turnaround and data MSB first while MDC is low.
    always @(negedge mdc) begin
        if (rd_act) begin
            rd_pos++;
            if (rd_pos == 0) mdio_i = 1'b0;
            else if (rd_pos <= 16) mdio_i = rd_word[16 - rd_pos];
            else begin
                rd_act = 0;
                mdio_i = 1'b1;
            end
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset(logic [N-1:0] an_off, logic [N-1:0] dpx, logic frc_n);
        @(negedge clk);
        rst_n = 1'b0;
        aneg_off_strap = an_off;
        duplex_strap   = dpx;
        force_link_n   = frc_n;
        nbits = 0; rd_act = 0; mdio_i = 1'b1;
        exp_phy = 0; exp_step = 0; fmt_err = 0; seq_err = 0; frames = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_sweeps(int n);
        int target;
        target = sweeps + n;
        wait (sweeps >= target);
        @(negedge clk);
    endtask

    task automatic set_phy(int p, logic [15:0] s, logic [15:0] a, logic [15:0] l);
        r1[p] = s; r4[p] = a; r5[p] = l;
    endtask

    // R10, R9: outputs straight after reset
    task automatic t_reset_state();
        do_reset(8'b1100_0000, 8'b0100_0000, 1'b1);
        check("R10 link after reset", 32'(link_up), 32'h00);
        check("R10 port reset after reset", 32'(port_rst_n), 32'h00);
        check("R9 strapped duplex after reset", 32'(full_duplex), 32'h40);
    endtask

    // R3: MDC period
    task automatic t_mdc_rate();
        int t0;
        @(posedge mdc); t0 = cyc;
        @(posedge mdc);
        check("R3 MDC period", 32'(cyc - t0), 32'(2 * HALF));
    endtask

    // R1, R2: one full sweep of well-formed frames in order
    task automatic t_frames();
        wait_sweeps(2);
        check("R2 frame format errors", 32'(fmt_err), 32'd0);
        check("R1 address/register order errors", 32'(seq_err), 32'd0);
        check("R1 frames per sweep seen", 32'(frames >= 3 * N), 32'd1);
    endtask

    // R4, R7, R8, R9: link and duplex after polling
    task automatic t_resolve();
        check("R4 link per port", 32'(link_up), 32'hDF);
        check("R4 port reset follows link", 32'(port_rst_n), 32'hDF);
        check("R7 R8 R9 duplex per port", 32'(full_duplex), 32'h65);
    endtask

    // R4, R8: link drop / recovery and incomplete negotiation hold
    task automatic t_change();
        r1[0] = 16'h0020;
        r1[5] = 16'h0024;
        set_phy(2, 16'h0004, 16'h0021, 16'h01E1);
        wait_sweeps(2);
        check("R4 link after change", 32'(link_up), 32'hFE ^ 32'h10 ^ 32'h10);
        check("R4 port reset after change", 32'(port_rst_n), 32'hFE);
        check("R8 duplex held when incomplete", 32'(full_duplex[2]), 32'd1);
    endtask

    // R6: strap pins changed after reset are ignored
    task automatic t_strap_latch();
        aneg_off_strap = 8'h00;
        duplex_strap   = 8'hFF;
        force_link_n   = 1'b0;
        wait_sweeps(2);
        check("R6 strapped duplex unchanged", 32'(full_duplex[7:6]), 32'h1);
        check("R6 force strap ignored after reset", 32'(link_up[0]), 32'd0);
    endtask

    // R5: forced link
    task automatic t_force();
        do_reset(8'b1100_0000, 8'b0100_0000, 1'b0);
        check("R5 forced link after reset", 32'(link_up), 32'hFF);
        wait_sweeps(2);
        check("R5 forced link with PHY down", 32'(link_up), 32'hFF);
        check("R5 forced port reset released", 32'(port_rst_n), 32'hFF);
    endtask

    task automatic run_all();
        set_phy(0, 16'h0024, 16'h01E1, 16'h01E1); // 100 full
        set_phy(1, 16'h0024, 16'h01E1, 16'h00E1); // 100 half beats 10 full
        set_phy(2, 16'h0024, 16'h0061, 16'h01E1); // 10 full
        set_phy(3, 16'h0024, 16'h0021, 16'h01E1); // 10 half
        set_phy(4, 16'h0004, 16'h01E1, 16'h01E1); // not complete
        set_phy(5, 16'h0020, 16'h01E1, 16'h01E1); // link down, complete
        set_phy(6, 16'h0024, 16'h01E1, 16'h0021); // strapped full
        set_phy(7, 16'h0024, 16'h01E1, 16'h01E1); // strapped half
        t_reset_state();
        t_mdc_rate();
        t_frames();
        t_resolve();
        t_change();
        t_strap_latch();
        t_force();
    endtask

    initial begin
        aneg_off_strap = '0;
        duplex_strap   = '0;
        force_link_n   = 1'b1;
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule